// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one external interrupt request pin and turns activity on it into a latched status flag and an interrupt request towards the processor. A four-bit configuration word sets it up. The word has a pin-enable bit, a polarity bit, a detection-mode bit and an interrupt-enable bit. Software reads the flag on its own output and clears it by pulsing a write-one acknowledge input.

Detection in normal operation is synchronous. The pin passes through a flop synchronizer into the system clock domain. An edge is found by comparing the current sample, normalized to the chosen polarity, with the sample from the cycle before. In edge-and-level mode the flag is also held for as long as the pin stays at its active level.

While the system clocks are stopped, a purely combinational path raises a wake request from the raw pin. That path contains no flop. The stop-mode controller and interrupt vectoring sit outside this block.

Top module: `irqdet_top`

## Requirements
- R1: After reset, `flag`, `irq` and `wake` are 0 and `cfg_rdata` is 0.
- R2: While `cfg_rdata[0]` (pin enable) is 0, the flag is cleared on the next clock and stays 0, and `irq` and `wake` stay 0 whatever the pin does.
- R3: `cfg_rdata[1]` selects the active sense. 0 means a falling edge or low level, and 1 means a rising edge or high level.
- R4: With `cfg_rdata[2]` = 0 (edges only), a change of `pin_in` to the active level before clock edge k sets `flag` at clock edge k+2. A change to the inactive level sets nothing.
- R5: With `cfg_rdata[2]` = 1 (edges and levels), the flag stays set while the synchronized pin sits at the active level, and an acknowledge during that time has no lasting effect.
- R6: `irq` equals `flag` when `cfg_rdata[3]` (interrupt enable) is 1, and is 0 otherwise. With the interrupt disabled, the flag can still be polled.
- R7: An `ack` pulse clears the flag on the next clock. If an acknowledge and a new event fall in the same cycle, the flag stays set. An event after a clear sets the flag again.
- R8: A configuration write reloads the edge history, so a polarity change on a steady pin raises no edge event.
- R9: `wake` equals 1 exactly when `clk_stopped` is 1, pin enable is 1, and the raw `pin_in` equals the polarity bit. This needs no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous external request pin |
| clk_stopped | input | 1 | High while system clocks are halted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration word: [0] enable, [1] polarity, [2] mode, [3] irq enable |
| ack | input | 1 | Write-one pulse clearing the flag |
| cfg_rdata | output | 4 | Current configuration word |
| flag | output | 1 | Latched event flag |
| irq | output | 1 | Interrupt request to the processor |
| wake | output | 1 | Clockless wake request |

## Verification
The bench builds the block with its default two-stage synchronizer, so every latency it checks is a fixed count of three clock edges. It sweeps all eight combinations of polarity, mode and interrupt enable. For each combination it covers: the first visible cycle of the flag, acknowledge against a held level, a polarity flip on a steady pin, and an acknowledge landing in the event cycle itself. It then takes the disabled state and the combinational wake path through every pin and stop combination.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;
  // Bit 0 sits at the low end of the packed word.
  typedef struct packed {
    logic irq_en;
    logic mode_level;
    logic pol_high;
    logic pin_en;
  } irqdet_cfg_t;

  localparam int CFG_W = $bits(irqdet_cfg_t);
endpackage

// File: rtl/irqdet_sync.sv
module irqdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqdet_event.sv
module irqdet_event (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  input  logic pin_en,
  input  logic pol_high,
  input  logic mode_level,
  input  logic cfg_we,
  input  logic wr_pol_high,
  output logic level_act,
  output logic evt
);
  logic prev_act;
  logic edge_hit;

  // The sample is normalized so that 1 always means "active".
  assign level_act = (pin_sync == pol_high);
  assign edge_hit  = level_act & ~prev_act;
  assign evt       = pin_en & (edge_hit | (mode_level & level_act));

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_act <= 1'b1;
    else if (cfg_we) prev_act <= (pin_sync == wr_pol_high);
    else             prev_act <= level_act;
  end

  // R8: after a write, an edge can come only from real pin movement
  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!edge_hit || (pin_sync != $past(pin_sync))));
endmodule

// File: rtl/irqdet_flag.sv
module irqdet_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic evt,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= en & (evt | (flag & ~ack));
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && evt) |=> flag);
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ack && !evt) |=> !flag);
endmodule

// File: rtl/irqdet_top.sv
module irqdet_top
  import irqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             clk_stopped,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ack,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             flag,
  output logic             irq,
  output logic             wake
);
  irqdet_cfg_t cfg_q;
  irqdet_cfg_t cfg_new;
  logic pin_sync;
  logic level_act;
  logic evt;

  assign cfg_new = irqdet_cfg_t'(cfg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_new;
  end

  irqdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  irqdet_event u_event (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
    .pin_en(cfg_q.pin_en), .pol_high(cfg_q.pol_high),
    .mode_level(cfg_q.mode_level), .cfg_we(cfg_we),
    .wr_pol_high(cfg_new.pol_high), .level_act(level_act), .evt(evt)
  );

  irqdet_flag u_flag (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.pin_en),
    .evt(evt), .ack(ack), .flag(flag)
  );

  assign cfg_rdata = cfg_q;
  assign irq       = flag & cfg_q.irq_en;
  // Clockless path: raw pin, no flop in the way.
  assign wake      = clk_stopped & cfg_q.pin_en & (pin_in == cfg_q.pol_high);

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.pin_en && !cfg_we) |=> !flag);
  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.pin_en && cfg_q.mode_level && level_act && !cfg_we) |=> flag);
  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.pin_en || !clk_stopped) |-> !wake);
endmodule

// File: tb/irqdet_top_test.sv
module irqdet_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0;
  logic clk_stopped = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic ack = 1'b0;
  logic [3:0] cfg_rdata;
  logic flag, irq, wake;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irqdet_top uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clk_stopped(clk_stopped),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ack(ack),
    .cfg_rdata(cfg_rdata), .flag(flag), .irq(irq), .wake(wake)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_cfg(input logic [3:0] w);
    cfg_wdata = w; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 flag", flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake", wake, 1'b0);
    chk("R1 cfg", cfg_rdata == 4'h0, 1'b1);
    rst_n = 1'b1;
    tick(1);

    for (int c = 0; c < 8; c++) begin
      logic pol, md, ie;
      logic [3:0] w;
      pol = c[0]; md = c[1]; ie = c[2];
      w = {ie, md, pol, 1'b1};
      pin_in = ~pol;              // inactive level
      tick(4);
      write_cfg(w);
      tick(3);
      pulse_ack();
      chk("R3 inactive level no flag", flag, 1'b0);
      chk("R6 irq quiet", irq, 1'b0);

      // R4 latency: set at third edge
      pin_in = pol;
      tick(2);
      chk("R4 flag not yet", flag, 1'b0);
      tick(1);
      chk("R4 flag on active edge", flag, 1'b1);
      chk("R6 irq follows enable", irq, ie);

      // R5 / R7: acknowledge while active
      pulse_ack();
      chk(md ? "R5 ack ignored at level" : "R7 ack clears", flag, md);
      tick(2);
      chk(md ? "R5 level holds" : "R4 single edge", flag, md);

      // back to inactive: no event in either mode
      pin_in = ~pol;
      tick(4);
      pulse_ack();
      chk("R4 inactive edge sets nothing", flag, 1'b0);

      // R8: flip polarity on a steady pin
      write_cfg({ie, md, ~pol, 1'b1});
      tick(4);
      chk(md ? "R8 level under new sense" : "R8 no spurious edge", flag, md);
      write_cfg(w);
      tick(1);
      pulse_ack();
      tick(1);
      chk("R8 restore clear", flag, 1'b0);

      // R7: acknowledge in the event cycle
      pin_in = pol;
      tick(2);
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
      chk("R7 set wins over ack", flag, 1'b1);
      if (!md) begin
        pulse_ack();
        chk("R7 later ack clears", flag, 1'b0);
      end
      pin_in = ~pol;
      tick(4);
      pulse_ack();
      chk("R7 cleared after release", flag, 1'b0);

      // R7: a new event after a clear sets again
      pin_in = pol;
      tick(3);
      chk("R7 re-set after clear", flag, 1'b1);
      pin_in = ~pol;
      tick(4);
      pulse_ack();

      // R9 wake path, combinational
      for (int s = 0; s < 4; s++) begin
        clk_stopped = s[0];
        pin_in = s[1];
        #0.5;
        chk("R9 wake", wake, s[0] & (s[1] == pol));
      end
      clk_stopped = 1'b0;
      pin_in = ~pol;
      tick(4);

      // R2: disable clears flag and blocks everything
      pin_in = pol;
      tick(3);
      write_cfg({ie, md, pol, 1'b0});
      tick(1);
      chk("R2 flag cleared on disable", flag, 1'b0);
      pin_in = ~pol; tick(3);
      pin_in = pol;  tick(4);
      chk("R2 no flag while disabled", flag, 1'b0);
      chk("R2 no irq while disabled", irq, 1'b0);
      clk_stopped = 1'b1;
      #0.5;
      chk("R2 no wake while disabled", wake, 1'b0);
      clk_stopped = 1'b0;
      chk("R2 cfg readback", cfg_rdata == {ie, md, pol, 1'b0}, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule